// File: doc/BRIEF.md
# Serial Configuration Bitstream Readout Sequencer

This block is the readout half of a serial memory that feeds configuration data to a programmable logic device. A byte-organised bit store holds the image. Each rising edge of the shift clock moves a bit pointer forward by one place. The bit under the pointer is presented on a data line. That line is driven only while the sequencer is allowed to talk. Two controls decide whether it may talk. The first is a combined reset/output-enable input, which is active low for reset. The second is an active-low select. The reset/output-enable input always wins over the select.

When the final stored bit has been shifted out, the sequencer stops driving the data line and pulls an active-low cascade output down. A second memory on the same line can then take over the stream. The pointer and the cascade state stay frozen until the reset/output-enable input is pulled low again. A synchronous power-up reset also returns the pointer to zero, without any such pulse.

The image is loaded through a byte-wide synchronous write port. The port accepts data only while reset/output-enable is low. The top level turns the internal data value and its enable into a real three-state pin, and it also brings the enable out as a separate signal. The shift clock is sampled by the system clock, so it must be well below the system clock rate.

Top module: `cfg_serial_mem`

## Requirements
- R1: While `rst_oe` is low, `data_oe` is low at once, whatever `cs_n` is. The bit pointer is cleared to address 0 at the next `clk` edge.
- R2: While `rst_oe` is high and `cs_n` is high, `data_oe` stays low and shift-clock edges do not move the pointer.
- R3: While `rst_oe` is high, `cs_n` is low and the end of data has not been reached, `data_oe` is high. DATA then carries the stored bit at the pointer. Bit address a maps to byte a/8, bit 7-(a mod 8), so each byte is sent most significant bit first.
- R4: A shift-clock rising edge is a 0-to-1 change of `dclk` between two consecutive `clk` edges. Each such edge advances the pointer by exactly one while enabled. A `dclk` held high for many cycles counts once.
- R5: After the DEPTH_BITS-th enabled shift-clock edge, `cascade_n` goes low and `data_oe` goes low. Further shift-clock edges and changes of `cs_n` leave both unchanged.
- R6: Once low, `cascade_n` returns high only through a `clk` edge at which `rst_oe` is low, or through `rst`.
- R7: `rst` is synchronous and active high. It sets the pointer to 0 and `cascade_n` high. It does not change the stored image.
- R8: With `wr_en` high and `rst_oe` low, `wr_data` is written into byte `wr_addr` at the `clk` edge. With `rst_oe` high, writes are ignored.
- R9: `data_io` carries the DATA bit while `data_oe` is high and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dclk | input | 1 | Shift clock, sampled on `clk` |
| rst_oe | input | 1 | Low: reset the pointer and release DATA; high: output enable |
| cs_n | input | 1 | Active-low select |
| wr_en | input | 1 | Image write strobe |
| wr_addr | input | BYTE_AW | Byte address for image writes |
| wr_data | input | 8 | Byte written into the image |
| data_io | inout | 1 | Three-state serial data pin |
| data_oe | output | 1 | High while the block drives `data_io` |
| cascade_n | output | 1 | Low once all bits have been sent |

## Verification
The bench builds the block with DEPTH_BITS set to 32, which gives a four-byte image. With that size a full stream, the end-of-data transition and the behaviour after it all fit into a few hundred cycles. The same setting keeps the bit-to-byte mapping at the byte seams in view: addresses 7, 8, 15 and 16. A known pattern is loaded at those addresses, so a wrong clear, a missed hold or a reversed bit order each shows up as a wrong value at a known address.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_HALT  = 2'd0,
        SEQ_SHIFT = 2'd1,
        SEQ_SPENT = 2'd2
    } seq_mode_t;

    typedef struct packed {
        logic drive;
        logic value;
        logic casc_n;
    } pin_ctrl_t;

    localparam int BYTE_W = 8;

    function automatic logic [2:0] msb_first(input logic [2:0] pos);
        return ~pos;
    endfunction

endpackage

// File: rtl/cfg_dclk_edge.sv
module cfg_dclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic dclk,
    output logic rise
);
    logic dclk_q;

    always_ff @(posedge clk) begin
        dclk_q <= dclk;
        if (rst) dclk_q <= dclk;
    end

    assign rise = dclk & ~dclk_q;

    assert_single_rise_R4: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
    import cfg_seq_pkg::*;
#(
    parameter  int DEPTH_BITS = 256,
    localparam int NBYTES     = DEPTH_BITS / BYTE_W,
    localparam int BYTE_AW    = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int AW         = $clog2(DEPTH_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rst_oe,
    input  logic                wr_en,
    input  logic [BYTE_AW-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic                rd_bit
);
    logic [DEPTH_BITS-1:0] image_q;
    logic                  wr_ok;

    assign wr_ok = wr_en & ~rst_oe;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (wr_ok && wr_addr == BYTE_AW'(b))
                image_q[b*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    logic [AW-1:0] slot;
    assign slot   = {rd_addr[AW-1:3], msb_first(rd_addr[2:0])};
    assign rd_bit = image_q[slot];

    assert_write_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rst_oe) |=> image_q == $past(image_q));

    assert_idle_kept_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> image_q == $past(image_q));

endmodule

// File: rtl/cfg_addr_ctrl.sv
module cfg_addr_ctrl
    import cfg_seq_pkg::*;
#(
    parameter  int DEPTH_BITS = 256,
    localparam int AW         = $clog2(DEPTH_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_oe,
    input  logic          cs_n,
    input  logic          step,
    output logic [AW-1:0] addr,
    output seq_mode_t     mode
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH_BITS - 1);

    logic [AW-1:0] addr_q;
    logic          spent_q;

    always_comb begin
        if (spent_q)              mode = SEQ_SPENT;
        else if (rst_oe && !cs_n) mode = SEQ_SHIFT;
        else                      mode = SEQ_HALT;
    end

    always_ff @(posedge clk) begin
        if (rst || !rst_oe) begin
            addr_q  <= '0;
            spent_q <= 1'b0;
        end else if (mode == SEQ_SHIFT && step) begin
            if (addr_q == LAST) spent_q <= 1'b1;
            else                addr_q  <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        !rst_oe |=> (addr_q == '0 && !spent_q));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (rst_oe && cs_n) |=> addr_q == $past(addr_q));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_oe && !cs_n && step && !spent_q && addr_q != LAST)
            |=> addr_q == $past(addr_q) + 1'b1);

    assert_spent_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (spent_q && rst_oe) |=> spent_q);

    assert_por_R7: assert property (@(posedge clk)
        rst |=> (addr_q == '0 && !spent_q));

endmodule

// File: rtl/cfg_out_ctrl.sv
module cfg_out_ctrl
    import cfg_seq_pkg::*;
(
    input  seq_mode_t mode,
    input  logic      cur_bit,
    output pin_ctrl_t pin
);
    always_comb begin
        pin.drive  = (mode == SEQ_SHIFT);
        pin.value  = cur_bit;
        pin.casc_n = (mode != SEQ_SPENT);
    end
endmodule

// File: rtl/cfg_serial_mem.sv
module cfg_serial_mem
    import cfg_seq_pkg::*;
#(
    parameter  int DEPTH_BITS = 256,
    localparam int NBYTES     = DEPTH_BITS / 8,
    localparam int BYTE_AW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dclk,
    input  logic               rst_oe,
    input  logic               cs_n,
    input  logic               wr_en,
    input  logic [BYTE_AW-1:0] wr_addr,
    input  logic [7:0]         wr_data,
    inout  wire                data_io,
    output logic               data_oe,
    output logic               cascade_n
);
    localparam int AW = $clog2(DEPTH_BITS);

    logic          step;
    logic [AW-1:0] addr;
    seq_mode_t     mode;
    logic          cur_bit;
    pin_ctrl_t     pin;

    cfg_dclk_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .dclk (dclk),
        .rise (step)
    );

    cfg_addr_ctrl #(.DEPTH_BITS(DEPTH_BITS)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .rst_oe (rst_oe),
        .cs_n   (cs_n),
        .step   (step),
        .addr   (addr),
        .mode   (mode)
    );

    cfg_bit_store #(.DEPTH_BITS(DEPTH_BITS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rst_oe  (rst_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_bit  (cur_bit)
    );

    cfg_out_ctrl u_out (
        .mode    (mode),
        .cur_bit (cur_bit),
        .pin     (pin)
    );

    assign data_io   = pin.drive ? pin.value : 1'bz;
    assign data_oe   = pin.drive;
    assign cascade_n = pin.casc_n;

    assert_quiet_when_spent_R5: assert property (@(posedge clk) disable iff (rst)
        !cascade_n |-> !data_oe);

    assert_drive_gate_R3: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (rst_oe && !cs_n));

endmodule

// File: tb/cfg_serial_mem_tb.sv
module cfg_serial_mem_tb;
    localparam int DEPTH = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclk = 1'b0;
    logic       rst_oe = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    wire        data_io;
    logic       data_oe;
    logic       cascade_n;

    int total = 0;
    int fails = 0;

    logic [7:0] img [4];

    cfg_serial_mem #(.DEPTH_BITS(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .dclk      (dclk),
        .rst_oe    (rst_oe),
        .cs_n      (cs_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .data_io   (data_io),
        .data_oe   (data_oe),
        .cascade_n (cascade_n)
    );

    always #5 clk = ~clk;

    // Table columns: [5] rst_oe, [4] cs_n, [3] shift pulse,
    // [2] expected data_oe, [1] expected bit, [0] expected cascade_n
    localparam logic [5:0] TBL [11] = '{
        6'b110001,  // R2 deselected, no drive
        6'b111001,  // R2 edge ignored while deselected
        6'b100111,  // R3 addr0 = 1
        6'b101101,  // R4 addr1 = 0
        6'b101111,  // R4 addr2 = 1
        6'b111001,  // R2 deselect mid stream
        6'b100111,  // R2 addr still 2 = 1
        6'b000001,  // R1 reset overrides select
        6'b100111,  // R1 addr0 = 1
        6'b101101,  // R1 addr1 = 0
        6'b101111   // R1 addr2 = 1 (addr4 would be 0)
    };

    function automatic logic exp_bit(input int a);
        return img[a / 8][7 - (a % 8)];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic pulse();
        dclk = 1'b1;
        @(negedge clk);
        dclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic reset_oe();
        rst_oe = 1'b0;
        @(negedge clk);
        rst_oe = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(input int b, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = 2'(b); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        img[0] = 8'hA5; img[1] = 8'h3C; img[2] = 8'hF0; img[3] = 8'h81;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7", "cascade_n after reset", cascade_n, 1'b1);
        chk("R1", "data_oe while rst_oe low", data_oe, 1'b0);

        for (int b = 0; b < 4; b++) load(b, img[b]);   // R8 legal writes

        for (int i = 0; i < 11; i++) begin
            rst_oe = TBL[i][5];
            cs_n   = TBL[i][4];
            if (TBL[i][3]) pulse();
            else begin @(negedge clk); @(negedge clk); end
            chk("R2/R3", $sformatf("table %0d data_oe", i), data_oe, TBL[i][2]);
            chk("R6", $sformatf("table %0d cascade_n", i), cascade_n, TBL[i][0]);
            if (TBL[i][2])
                chk("R9", $sformatf("table %0d data_io", i), data_io, TBL[i][1]);
        end

        // R4: dclk held high for several clocks advances only once
        cs_n = 1'b0; reset_oe();
        dclk = 1'b1;
        repeat (5) @(negedge clk);
        dclk = 1'b0;
        @(negedge clk);
        chk("R4", "held dclk gives addr1", data_io, exp_bit(1));
        pulse();
        chk("R4", "next edge gives addr2", data_io, exp_bit(2));

        // R3/R5: full stream from address 0
        reset_oe();
        for (int a = 0; a < DEPTH; a++) begin
            chk("R3", $sformatf("stream oe at %0d", a), data_oe, 1'b1);
            chk("R3", $sformatf("stream bit %0d", a), data_io, exp_bit(a));
            chk("R5", $sformatf("cascade high at %0d", a), cascade_n, 1'b1);
            pulse();
        end
        chk("R5", "cascade low at end", cascade_n, 1'b0);
        chk("R5", "data released at end", data_oe, 1'b0);
        pulse(); pulse();
        cs_n = 1'b1; @(negedge clk);
        cs_n = 1'b0; @(negedge clk);
        chk("R6", "cascade stays low", cascade_n, 1'b0);
        chk("R5", "still released", data_oe, 1'b0);

        // R6: rst_oe low brings cascade back
        reset_oe();
        chk("R6", "cascade high after rst_oe pulse", cascade_n, 1'b1);
        chk("R1", "addr0 after rst_oe pulse", data_io, exp_bit(0));

        // R8: write while rst_oe high is ignored
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        reset_oe();
        for (int a = 0; a < 8; a++) begin
            chk("R8", $sformatf("byte0 kept bit %0d", a), data_io, exp_bit(a));
            pulse();
        end

        // R8: write while rst_oe low takes effect
        rst_oe = 1'b0;
        @(negedge clk);
        load(1, 8'hFF);
        img[1] = 8'hFF;
        rst_oe = 1'b1;
        @(negedge clk);
        repeat (8) pulse();
        chk("R8", "new byte1 bit 8", data_io, 1'b1);
        pulse();
        chk("R8", "new byte1 bit 9", data_io, 1'b1);

        // R7: synchronous reset mid stream, image kept
        repeat (3) pulse();
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R7", "addr0 after rst", data_io, exp_bit(0));
        chk("R7", "drive after rst", data_oe, 1'b1);

        // R7: reset after end of data restores cascade
        repeat (DEPTH) pulse();
        chk("R5", "cascade low before rst", cascade_n, 1'b0);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R7", "cascade high after rst", cascade_n, 1'b1);
        chk("R9", "bit addr0 on pin after rst", data_io, exp_bit(0));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule